// File: doc/BRIEF.md
# Sector Erase Queue with Retriggerable Acceptance Window

This block gathers the set of sectors that one erase operation will clear. When a sector-erase command arrives while the block is idle, it turns the sector index into a one-hot bit, stores that bit in a sector bitmap and opens an acceptance window. The window length is a run-time count of clock cycles. Further sector-erase commands that arrive before the window runs out add their bits to the bitmap, in any order. Each accepted command starts the window again.

When the window runs out, the block emits a one-cycle erase-start pulse. The finished bitmap is presented on the bitmap output, and a window-closed status bit goes high. That status bit stays high, and the bitmap stays frozen, until the erase engine signals completion. A command that is neither a sector erase nor an erase suspend, arriving while the window is open, discards the whole queue and sends the block back to idle.

Top module: `sector_erase_queue`

## Requirements
- R1: While reset is asserted, and right after it, erase_map is all zero, erase_start is low and window_closed is low.
- R2: A command with cmd_valid high and cmd_code 2'b01 (sector erase) accepted in the idle state loads erase_map with only bit sec_idx set (bit position equals the index). The map is visible one clock after the command edge.
- R3: Each further sector-erase command inside the window ORs its one-hot bit into erase_map. Order does not matter, repeating an index changes nothing, and all NUM_SECTORS bits can be set.
- R4: Each accepted sector-erase command reloads the window. erase_start rises win_len clock edges after the edge of the last accepted command, and a win_len of 0 acts as 1. A command arriving on the last edge of the window is still accepted and restarts the window.
- R5: erase_start is exactly one cycle wide and carries the final bitmap. window_closed rises in the same cycle and stays high until eng_done.
- R6: A command with cmd_code 2'b00 or 2'b11 while the window is open clears erase_map and returns the block to idle. The erase-start pulse that was due never occurs.
- R7: An erase-suspend command (cmd_code 2'b10) during the window leaves erase_map unchanged and does not restart the window.
- R8: While window_closed is high, every command is ignored: the map does not change and no new pulse occurs. On eng_done the map clears, window_closed falls, and the next sector-erase command is accepted.
- R9: In the idle state, any command other than a sector erase has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 2 | 01 sector erase, 10 erase suspend, 00/11 any other command |
| sec_idx | input | IDX_W | Sector index taken from the upper address bits |
| win_len | input | CNT_W | Acceptance window length in clock cycles |
| eng_done | input | 1 | Erase engine has finished and is idle again |
| erase_map | output | NUM_SECTORS | Queued sector bitmap, one bit per sector |
| erase_start | output | 1 | One-cycle pulse that hands erase_map to the engine |
| window_closed | output | 1 | High from the erase-start pulse until eng_done |

## Verification
A command sampled at clock edge k changes erase_map and window_closed just after edge k. erase_start comes due just after edge k plus win_len, counted from the last accepted command. The bench changes its inputs 1 ns after an edge and reads the outputs 1 ns after the following edge, so every expected value in the vector table belongs to the edge that row stimulates. Window expiry is probed with commands on the final window edge and with the window length set to zero. Aborted windows are watched past the edge on which their pulse would have fallen.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    CMD_OTHER_LO = 2'b00,
    CMD_SECTOR   = 2'b01,
    CMD_SUSPEND  = 2'b10,
    CMD_OTHER_HI = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_OPEN  = 2'b01,
    ST_ERASE = 2'b10
  } state_e;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/seq_onehot.sv
module seq_onehot #(
  parameter int NUM_SECTORS = 8,
  localparam int IDX_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic [IDX_W-1:0]       idx,
  output logic [NUM_SECTORS-1:0] onehot
);
  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_bit
    assign onehot[g] = (idx == IDX_W'(g));
  end

  // R2: the decoded sector never selects more than one bit
  always_comb begin
    a_r2_onehot: assert ($onehot0(onehot));
  end
endmodule

// File: rtl/seq_window_timer.sv
module seq_window_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] len,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = (len == '0) ? CNT_W'(1) : len;
    end else if (run && cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load | run) cnt_q <= cnt_d;
  end

  assign expire = (cnt_q <= CNT_W'(1));

  // R4: a load always leaves a non-zero remaining window
  a_r4_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !(cnt_q == '0));
endmodule

// File: rtl/sector_erase_queue.sv
module sector_erase_queue
  import seq_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int CNT_W = 16,
  localparam int IDX_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_code,
  input  logic [IDX_W-1:0]       sec_idx,
  input  logic [CNT_W-1:0]       win_len,
  input  logic                   eng_done,
  output logic [NUM_SECTORS-1:0] erase_map,
  output logic                   erase_start,
  output logic                   window_closed
);
  logic rst_ns;
  seq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns));

  logic [NUM_SECTORS-1:0] sec_bit;
  seq_onehot #(.NUM_SECTORS(NUM_SECTORS)) u_dec (.idx(sec_idx), .onehot(sec_bit));

  state_e                 state_q, state_d;
  logic [NUM_SECTORS-1:0] map_q, map_d;
  logic                   start_q, start_d;
  logic                   tmr_load, tmr_run, tmr_expire;
  cmd_e                   code;
  logic                   is_sector, is_foreign;

  assign code       = cmd_e'(cmd_code);
  assign is_sector  = cmd_valid && (code == CMD_SECTOR);
  assign is_foreign = cmd_valid && (code != CMD_SECTOR) && (code != CMD_SUSPEND);

  seq_window_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_ns), .load(tmr_load), .run(tmr_run),
    .len(win_len), .expire(tmr_expire)
  );

  always_comb begin
    state_d  = state_q;
    map_d    = map_q;
    start_d  = 1'b0;
    tmr_load = 1'b0;
    tmr_run  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (is_sector) begin
          map_d    = sec_bit;
          tmr_load = 1'b1;
          state_d  = ST_OPEN;
        end
      end
      ST_OPEN: begin
        tmr_run = 1'b1;
        if (is_foreign) begin
          map_d   = '0;
          state_d = ST_IDLE;
        end else if (is_sector) begin
          map_d    = map_q | sec_bit;
          tmr_load = 1'b1;
        end else if (tmr_expire) begin
          start_d = 1'b1;
          state_d = ST_ERASE;
        end
      end
      ST_ERASE: begin
        if (eng_done) begin
          map_d   = '0;
          state_d = ST_IDLE;
        end
      end
      default: begin
        map_d   = '0;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      map_q   <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      map_q   <= map_d;
      start_q <= start_d;
    end
  end

  assign erase_map     = map_q;
  assign erase_start   = start_q;
  assign window_closed = (state_q == ST_ERASE);

  // R5: the start pulse lasts one cycle
  a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_ns)
    erase_start |=> !erase_start);
  // R5: the status bit is already high when the pulse appears
  a_r5_start_closed: assert property (@(posedge clk) disable iff (!rst_ns)
    erase_start |-> window_closed);
  // R8: the bitmap stays frozen while the erase runs
  a_r8_map_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (window_closed && !eng_done) |=> (window_closed && $stable(erase_map)));
  // R6: a foreign command during the window empties the queue
  a_r6_foreign_clear: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_OPEN && is_foreign) |=> (erase_map == '0 && !window_closed));
  // R3: bits are only ever added while the window is open
  a_r3_accumulate: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_OPEN && is_sector) |=> ((erase_map & $past(erase_map)) == $past(erase_map)));
endmodule

// File: tb/sector_erase_queue_bench.sv
module sector_erase_queue_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_code = 2'b00;
  logic [2:0]  sec_idx = 3'd0;
  logic [15:0] win_len = 16'd3;
  logic        eng_done = 1'b0;
  logic [7:0]  erase_map;
  logic        erase_start;
  logic        window_closed;

  int checks = 0;
  int errors = 0;
  bit reported = 1'b0;

  always #2 clk = ~clk;

  sector_erase_queue u_sector_erase_queue (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .sec_idx(sec_idx), .win_len(win_len), .eng_done(eng_done),
    .erase_map(erase_map), .erase_start(erase_start), .window_closed(window_closed)
  );

  typedef struct packed {
    logic       v;
    logic [1:0] code;
    logic [2:0] idx;
    logic       done;
    logic [7:0] map;
    logic       st;
    logic       cl;
    logic [3:0] req;
  } vec_t;

  // inputs of one cycle and outputs expected after that edge, window length 3
  localparam vec_t VECS [0:24] = '{
    '{1'b1, 2'b01, 3'd2, 1'b0, 8'h04, 1'b0, 1'b0, 4'd2},  // R2 first sector
    '{1'b0, 2'b00, 3'd0, 1'b0, 8'h04, 1'b0, 1'b0, 4'd4},
    '{1'b1, 2'b01, 3'd5, 1'b0, 8'h24, 1'b0, 1'b0, 4'd3},  // R3 add sector
    '{1'b1, 2'b01, 3'd2, 1'b0, 8'h24, 1'b0, 1'b0, 4'd3},  // R3 duplicate
    '{1'b0, 2'b00, 3'd0, 1'b0, 8'h24, 1'b0, 1'b0, 4'd4},
    '{1'b1, 2'b10, 3'd1, 1'b0, 8'h24, 1'b0, 1'b0, 4'd7},  // R7 suspend
    '{1'b0, 2'b00, 3'd0, 1'b0, 8'h24, 1'b1, 1'b1, 4'd5},  // R5 start
    '{1'b1, 2'b01, 3'd0, 1'b0, 8'h24, 1'b0, 1'b1, 4'd8},  // R8 ignored
    '{1'b0, 2'b00, 3'd0, 1'b0, 8'h24, 1'b0, 1'b1, 4'd8},
    '{1'b0, 2'b00, 3'd0, 1'b1, 8'h00, 1'b0, 1'b0, 4'd8},  // R8 done
    '{1'b1, 2'b11, 3'd3, 1'b0, 8'h00, 1'b0, 1'b0, 4'd9},  // R9 idle foreign
    '{1'b1, 2'b01, 3'd7, 1'b0, 8'h80, 1'b0, 1'b0, 4'd2},
    '{1'b1, 2'b00, 3'd4, 1'b0, 8'h00, 1'b0, 1'b0, 4'd6},  // R6 abort
    '{1'b0, 2'b00, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 4'd6},
    '{1'b0, 2'b00, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 4'd6},
    '{1'b0, 2'b00, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 4'd6},
    '{1'b1, 2'b01, 3'd1, 1'b0, 8'h02, 1'b0, 1'b0, 4'd2},
    '{1'b0, 2'b00, 3'd0, 1'b0, 8'h02, 1'b0, 1'b0, 4'd4},
    '{1'b0, 2'b00, 3'd0, 1'b0, 8'h02, 1'b0, 1'b0, 4'd4},
    '{1'b1, 2'b01, 3'd6, 1'b0, 8'h42, 1'b0, 1'b0, 4'd4},  // R4 last-edge retrigger
    '{1'b0, 2'b00, 3'd0, 1'b0, 8'h42, 1'b0, 1'b0, 4'd4},
    '{1'b0, 2'b00, 3'd0, 1'b0, 8'h42, 1'b0, 1'b0, 4'd4},
    '{1'b0, 2'b00, 3'd0, 1'b0, 8'h42, 1'b1, 1'b1, 4'd4},
    '{1'b0, 2'b00, 3'd0, 1'b0, 8'h42, 1'b0, 1'b1, 4'd5},
    '{1'b0, 2'b00, 3'd0, 1'b1, 8'h00, 1'b0, 1'b0, 4'd8}
  };

  task automatic chk(input string req, input logic [7:0] m, input logic s, input logic c);
    checks++;
    if (erase_map !== m || erase_start !== s || window_closed !== c) begin
      errors++;
      $display("FAIL %s t=%0t map/start/closed actual %h/%b/%b expected %h/%b/%b",
               req, $time, erase_map, erase_start, window_closed, m, s, c);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] code, input logic [2:0] idx,
                      input logic done);
    cmd_valid = v; cmd_code = code; sec_idx = idx; eng_done = done;
    @(posedge clk); #1;
    cmd_valid = 1'b0; eng_done = 1'b0;
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1", 8'h00, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R1", 8'h00, 1'b0, 1'b0);

    foreach (VECS[i]) begin
      step(VECS[i].v, VECS[i].code, VECS[i].idx, VECS[i].done);
      chk($sformatf("R%0d row %0d", VECS[i].req, i), VECS[i].map, VECS[i].st, VECS[i].cl);
    end

    // R9: suspend in idle does nothing
    step(1'b1, 2'b10, 3'd2, 1'b0);
    chk("R9 idle suspend", 8'h00, 1'b0, 1'b0);
    step(1'b0, 2'b00, 3'd0, 1'b0);
    chk("R9 idle suspend", 8'h00, 1'b0, 1'b0);

    // R3: fill every sector in descending order
    for (int k = 7; k >= 0; k--) step(1'b1, 2'b01, 3'(k), 1'b0);
    chk("R3 all sectors", 8'hFF, 1'b0, 1'b0);
    step(1'b0, 2'b00, 3'd0, 1'b0);
    step(1'b0, 2'b00, 3'd0, 1'b0);
    chk("R4 before expiry", 8'hFF, 1'b0, 1'b0);
    step(1'b0, 2'b00, 3'd0, 1'b0);
    chk("R5 full map start", 8'hFF, 1'b1, 1'b1);
    step(1'b0, 2'b00, 3'd0, 1'b1);
    chk("R8 done clears", 8'h00, 1'b0, 1'b0);

    // R4: window length 0 behaves as 1
    win_len = 16'd0;
    step(1'b1, 2'b01, 3'd3, 1'b0);
    chk("R4 zero window accept", 8'h08, 1'b0, 1'b0);
    step(1'b0, 2'b00, 3'd0, 1'b0);
    chk("R4 zero window start", 8'h08, 1'b1, 1'b1);
    step(1'b0, 2'b00, 3'd0, 1'b1);
    step(1'b1, 2'b01, 3'd4, 1'b0);
    chk("R8 accept after done", 8'h10, 1'b0, 1'b0);

    // R1: reset in the middle of a window
    rst_n = 1'b0;
    #1 chk("R1 reset mid window", 8'h00, 1'b0, 1'b0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk("R1 after reset", 8'h00, 1'b0, 1'b0);

    report();
    $finish;
  end
endmodule